// File: doc/BRIEF.md
# Multi-Bank Asynchronous Memory Controller

This block turns 32-bit word requests from a core into cycles on an external asynchronous memory bus shared by four chip-select banks. The top address bits pick the bank. The bank's select line is held low for the whole access. Read and write strobes are timed from a setup, strobe-active and hold count that each bank keeps for itself.

Each bank can be 8, 16 or 32 bits wide. On a narrow bank one core word is split into four or two external transfers, lowest part first. Read parts are packed back into a single core word. The core sees one completion pulse after the last transfer. Bank 0 answers only in the lower part of its address region. The rest of that region is a hole: a request there completes with an error and drives no strobes.

The core holds `req_i` and its address and data until `ready_o` pulses, then drops the request on the next edge. Timing and width are written per bank through a small configuration port.

Top module: `async_mem_ctrl`

## Requirements
- R1: The bank is `addr_i[25:24]`. During an access only that bank's `cs_no` bit is low, and at all other times `cs_no` is all ones.
- R2: Bank 0 accepts offsets `addr_i[23:0]` below 0xE00000 (14M words). Banks 1 to 3 accept all 16M offsets. A request at bank 0 offset 0xE00000 or above asserts `ready_o` with `err_o` high on the cycle after acceptance and asserts no strobe and no select.
- R3: A write on `cfg_we_i` stores `cfg_data_i` for bank `cfg_bank_i` only. The fields are [13:12] width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), [11:8] setup, [7:4] active and [3:0] hold, all in clocks. After reset every bank is 32-bit, with setup 1, active 2 and hold 1.
- R4: Each transfer takes setup cycles with the select low and the strobes high, then active cycles with the strobe low, then hold cycles with the strobe high. An active value of 0 acts as 1. `ready_o` is seen 1 + n·(setup + active + hold) clock edges after the edge that accepts the request, where n is the number of transfers.
- R5: An 8-bit bank makes 4 transfers and a 16-bit bank makes 2, on `ext_addr_o` = offset·n + part, part 0 first. On part p, `ext_wdata_o` carries bits [p·w +: w] of the write word in its low w bits.
- R6: A read samples `ext_rdata_i` (its low w bits) on the edge that ends the read strobe. Part p lands in `rdata_o[p·w +: w]`, and `rdata_o` is valid while `ready_o` is high.
- R7: `ready_o` is a one-cycle pulse after the last transfer. `err_o` is low for every access inside a bank window.
- R8: The read and write strobes are never low together. A write asserts only `wr_no` and a read only `rd_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 26 | Core word address |
| wdata_i | input | 32 | Core write word |
| ready_o | output | 1 | Access complete pulse |
| err_o | output | 1 | Address outside every window, with ready |
| rdata_o | output | 32 | Assembled read word |
| cfg_we_i | input | 1 | Configuration write |
| cfg_bank_i | input | 2 | Bank being configured |
| cfg_data_i | input | 14 | Width and timing fields |
| ext_addr_o | output | 26 | External address |
| ext_wdata_o | output | 32 | External write data |
| ext_rdata_i | input | 32 | External read data |
| cs_no | output | 4 | Bank selects, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
Reads and writes go to all four banks. Each bank has a different width and timing set, so a packing error, a lane swap or a timing field read from the wrong bank shows up as a wrong word, a wrong transfer address or a wrong completion cycle. The external memory model returns a value that depends on the address, which tells apart which part of a narrow read was placed where. Bank 3 is never configured, so its accesses show the reset timing. A bank with a zero active count and another with zero setup and hold probe the edges of the timing. Requests at the first and last bank 0 hole addresses, and at the last valid bank 0 word, fix the window boundary.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef struct packed {
    logic [1:0] width;   // 0: 8-bit, 1: 16-bit, else 32-bit
    logic [3:0] setup;
    logic [3:0] active;
    logic [3:0] hold;
  } bank_cfg_t;

  localparam bank_cfg_t CFG_RST = '{width: 2'd2, setup: 4'd1, active: 4'd2, hold: 4'd1};

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_DONE} amc_state_t;
endpackage

// File: rtl/amc_cfg_regs.sv
module amc_cfg_regs
  import amc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BSEL_W = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BSEL_W-1:0] bank_i,
  input  bank_cfg_t         data_i,
  output bank_cfg_t         cfg_o [NUM_BANKS]
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_o[b] <= CFG_RST;
      else if (we_i && bank_i == BSEL_W'(b)) cfg_o[b] <= data_i;
    end
  end
endmodule

// File: rtl/amc_decode.sv
module amc_decode #(
  parameter int ADDR_W      = 26,
  parameter int NUM_BANKS   = 4,
  parameter int BANK0_WORDS = 14 * 2**20,
  localparam int BSEL_W = $clog2(NUM_BANKS),
  localparam int OFF_W  = ADDR_W - BSEL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BSEL_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              hit_o
);
  assign bank_o = addr_i[ADDR_W-1 -: BSEL_W];
  assign off_o  = addr_i[OFF_W-1:0];
  // windows stay at fixed bases; the bank 0 tail is a hole, not remapped
  assign hit_o  = (bank_o != '0) || ({1'b0, off_o} < (OFF_W+1)'(BANK0_WORDS));
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFF_W     = 24,
  parameter int DATA_W    = 32,
  localparam int BSEL_W = $clog2(NUM_BANKS),
  localparam int EXT_W  = OFF_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BSEL_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  bank_cfg_t         cfg_i [NUM_BANKS],
  output logic              ready_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [EXT_W-1:0]  ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [NUM_BANKS-1:0] cs_no,
  output logic              rd_no,
  output logic              wr_no
);
  amc_state_t st;
  logic [3:0]        cnt;
  logic [1:0]        part, last_part;
  logic [BSEL_W-1:0] bank_q;
  logic [OFF_W-1:0]  off_q;
  logic              we_q, err_q;
  logic [DATA_W-1:0] wdata_q, rbuf;
  bank_cfg_t         cfg_q, cfg_new;
  logic [3:0]        act_q, act_new;
  logic [4:0]        shamt;
  amc_state_t        first_st;
  logic [3:0]        first_cnt;

  assign cfg_new = cfg_i[bank_i];
  assign act_new = (cfg_new.active == 4'd0) ? 4'd1 : cfg_new.active;
  assign act_q   = (cfg_q.active == 4'd0) ? 4'd1 : cfg_q.active;

  // start of a following part: skip phases whose count is zero
  assign first_st  = (cfg_q.setup != 4'd0) ? ST_SETUP : ST_ACTIVE;
  assign first_cnt = (cfg_q.setup != 4'd0) ? cfg_q.setup - 4'd1 : act_q - 4'd1;

  always_comb begin
    case (cfg_q.width)
      2'd0:    begin last_part = 2'd3; shamt = {part, 3'b000};        ext_addr_o = {off_q, part}; end
      2'd1:    begin last_part = 2'd1; shamt = {part[0], 4'b0000};    ext_addr_o = {1'b0, off_q, part[0]}; end
      default: begin last_part = 2'd0; shamt = 5'd0;                  ext_addr_o = {2'b00, off_q}; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; part <= '0; bank_q <= '0; off_q <= '0;
      we_q <= 1'b0; err_q <= 1'b0; wdata_q <= '0; rbuf <= '0; cfg_q <= CFG_RST;
    end else begin
      case (st)
        ST_IDLE: if (req_i) begin
          bank_q <= bank_i; off_q <= off_i; we_q <= we_i; wdata_q <= wdata_i;
          part <= '0; rbuf <= '0; cfg_q <= cfg_new; err_q <= !hit_i;
          if (!hit_i) st <= ST_DONE;
          else if (cfg_new.setup != 4'd0) begin st <= ST_SETUP; cnt <= cfg_new.setup - 4'd1; end
          else begin st <= ST_ACTIVE; cnt <= act_new - 4'd1; end
        end
        ST_SETUP:
          if (cnt == 4'd0) begin st <= ST_ACTIVE; cnt <= act_q - 4'd1; end
          else cnt <= cnt - 4'd1;
        ST_ACTIVE:
          if (cnt == 4'd0) begin
            if (!we_q) begin
              case (cfg_q.width)
                2'd0:    rbuf[shamt +: 8]  <= ext_rdata_i[7:0];
                2'd1:    rbuf[shamt +: 16] <= ext_rdata_i[15:0];
                default: rbuf <= ext_rdata_i;
              endcase
            end
            if (cfg_q.hold != 4'd0) begin st <= ST_HOLD; cnt <= cfg_q.hold - 4'd1; end
            else if (part == last_part) st <= ST_DONE;
            else begin part <= part + 2'd1; st <= first_st; cnt <= first_cnt; end
          end else cnt <= cnt - 4'd1;
        ST_HOLD:
          if (cnt == 4'd0) begin
            if (part == last_part) st <= ST_DONE;
            else begin part <= part + 2'd1; st <= first_st; cnt <= first_cnt; end
          end else cnt <= cnt - 4'd1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic busy;
  assign busy        = (st == ST_SETUP) || (st == ST_ACTIVE) || (st == ST_HOLD);
  assign cs_no       = busy ? ~(NUM_BANKS'(1) << bank_q) : '1;
  assign rd_no       = !((st == ST_ACTIVE) && !we_q);
  assign wr_no       = !((st == ST_ACTIVE) && we_q);
  assign ext_wdata_o = wdata_q >> shamt;
  assign ready_o     = (st == ST_DONE);
  assign err_o       = (st == ST_DONE) && err_q;
  assign rdata_o     = rbuf;

  assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  assert_strobe_in_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> (cs_no != '1));
  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && err_o) |-> ($past(cs_no) == '1 && $past(rd_no) && $past(wr_no)));
  assert_addr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACTIVE && $past(st) == ST_ACTIVE && $past(part) == part) |-> $stable(ext_addr_o));
  assert_ready_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 32,
  parameter int NUM_BANKS   = 4,
  parameter int BANK0_WORDS = 14 * 2**20,
  localparam int BSEL_W = $clog2(NUM_BANKS),
  localparam int OFF_W  = ADDR_W - BSEL_W,
  localparam int CFG_W  = $bits(bank_cfg_t)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 ready_o,
  output logic                 err_o,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 cfg_we_i,
  input  logic [BSEL_W-1:0]    cfg_bank_i,
  input  logic [CFG_W-1:0]     cfg_data_i,
  output logic [OFF_W+1:0]     ext_addr_o,
  output logic [DATA_W-1:0]    ext_wdata_o,
  input  logic [DATA_W-1:0]    ext_rdata_i,
  output logic [NUM_BANKS-1:0] cs_no,
  output logic                 rd_no,
  output logic                 wr_no
);
  bank_cfg_t         cfg [NUM_BANKS];
  logic [BSEL_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic              hit;

  amc_cfg_regs #(.NUM_BANKS(NUM_BANKS)) cfg_regs_i (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .bank_i(cfg_bank_i),
    .data_i(bank_cfg_t'(cfg_data_i)), .cfg_o(cfg)
  );

  amc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK0_WORDS(BANK0_WORDS)) decode_i (
    .addr_i, .bank_o(bank), .off_o(off), .hit_o(hit)
  );

  amc_seq #(.NUM_BANKS(NUM_BANKS), .OFF_W(OFF_W), .DATA_W(DATA_W)) seq_i (
    .clk_i, .rst_ni, .req_i, .we_i, .bank_i(bank), .off_i(off), .hit_i(hit),
    .wdata_i, .cfg_i(cfg), .ready_o, .err_o, .rdata_o, .ext_addr_o,
    .ext_wdata_o, .ext_rdata_i, .cs_no, .rd_no, .wr_no
  );
endmodule

// File: tb/async_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module async_mem_ctrl_tb_top;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [25:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready, err;
  logic [31:0] rdata;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [13:0] cfg_data = '0;
  logic [25:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;
  logic [3:0]  cs_n;
  logic        rd_n, wr_n;

  always #2 clk = ~clk;

  function automatic logic [31:0] mem_f(logic [25:0] a);
    return (32'h9E3779B1 * {6'b0, a}) ^ 32'h0F1E2D3C;
  endfunction
  assign ext_rdata = mem_f(ext_addr);

  async_mem_ctrl dut_i (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .err_o(err), .rdata_o(rdata), .cfg_we_i(cfg_we),
    .cfg_bank_i(cfg_bank), .cfg_data_i(cfg_data), .ext_addr_o(ext_addr),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata), .cs_no(cs_n), .rd_no(rd_n), .wr_no(wr_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int bw [4] = '{2, 2, 2, 2};
  int bs [4] = '{1, 1, 1, 1};
  int ba [4] = '{2, 2, 2, 2};
  int bh [4] = '{1, 1, 1, 1};

  // transfer monitor
  int          n_xfer = 0, cs_bad = 0, both_bad = 0, wr_seen = 0, rd_seen = 0;
  logic [25:0] log_addr [8];
  logic [31:0] log_data [8];
  logic [3:0]  exp_cs = 4'hF;
  logic        prev_strobe = 1'b0;
  logic [25:0] prev_addr = '0;

  always @(negedge clk) begin
    logic strobe;
    strobe = !rd_n || !wr_n;
    if (strobe && (!prev_strobe || ext_addr != prev_addr)) begin
      if (n_xfer < 8) begin log_addr[n_xfer] = ext_addr; log_data[n_xfer] = ext_wdata; end
      n_xfer++;
    end
    if (!wr_n) wr_seen++;
    if (!rd_n) rd_seen++;
    if (strobe && cs_n !== exp_cs) cs_bad++;
    if (!strobe && cs_n !== 4'hF && cs_n !== exp_cs) cs_bad++;
    if (!rd_n && !wr_n) both_bad++;
    prev_strobe = strobe; prev_addr = ext_addr;
  end

  task automatic check(string req_tag, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic cfg_bank_wr(int b, int w, int s, int a, int h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'(b);
    cfg_data = {2'(w), 4'(s), 4'(a), 4'(h)};
    bw[b] = w; bs[b] = s; ba[b] = a; bh[b] = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(logic w_en, logic [25:0] a, logic [31:0] d, logic exp_err);
    int b, sh, n, wd, t, cyc;
    logic [63:0] mask;
    logic [31:0] exp_rd;
    logic [25:0] off;
    b = int'(a[25:24]); off = {2'b0, a[23:0]};
    sh = (bw[b] == 0) ? 2 : (bw[b] == 1) ? 1 : 0;
    n = 1 << sh; wd = 32 >> sh;
    mask = (64'd1 << wd) - 64'd1;
    t = bs[b] + ((ba[b] == 0) ? 1 : ba[b]) + bh[b];
    @(negedge clk);
    n_xfer = 0; cs_bad = 0; both_bad = 0; wr_seen = 0; rd_seen = 0;
    exp_cs = ~(4'b1 << b);
    req = 1'b1; we = w_en; addr = a; wdata = d;
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!ready && cyc < 400);
    req = 1'b0;
    if (exp_err) begin
      check("R2", 64'(err), 64'd1, "err flag on hole");
      check("R2", 64'(cyc), 64'd1, "hole completion cycles");
      check("R2", 64'(n_xfer + cs_bad), 64'd0, "strobes/selects on hole");
      return;
    end
    check("R7", 64'(err), 64'd0, "err flag on valid access");
    check("R4", 64'(cyc), 64'(1 + n * t), "ready cycle");
    check("R5", 64'(n_xfer), 64'(n), "transfer count");
    check("R1", 64'(cs_bad), 64'd0, "wrong select");
    check("R8", 64'(both_bad), 64'd0, "both strobes low");
    check("R8", 64'(w_en ? rd_seen : wr_seen), 64'd0, "wrong strobe type");
    if (w_en) begin
      for (int p = 0; p < n && p < 8; p++) begin
        check("R5", 64'(log_addr[p]), 64'(((off << sh) + 26'(p))), "write part address");
        check("R5", 64'(log_data[p]) & mask, (64'(d) >> (p * wd)) & mask, "write part data");
      end
    end else begin
      exp_rd = '0;
      for (int p = 0; p < n; p++)
        exp_rd |= 32'((64'(mem_f((off << sh) + 26'(p))) & mask) << (p * wd));
      check("R6", 64'(rdata), 64'(exp_rd), "assembled read word");
    end
  endtask

  // {we, addr, wdata}
  localparam logic [58:0] VEC [10] = '{
    {1'b1, 26'h0000010, 32'h11223344},
    {1'b0, 26'h0000010, 32'h0},
    {1'b1, 26'h1000005, 32'hA1B2C3D4},
    {1'b0, 26'h10FFFFF, 32'h0},
    {1'b1, 26'h2000003, 32'hCAFEF00D},
    {1'b0, 26'h2ABCDEF, 32'h0},
    {1'b1, 26'h3FFFFFF, 32'h01234567},
    {1'b0, 26'h3000000, 32'h0},
    {1'b0, 26'h0DFFFFF, 32'h0},
    {1'b0, 26'h1000000, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3 / R1: reset state of the bus
    check("R1", 64'(cs_n), 64'hF, "selects after reset");
    check("R8", 64'({rd_n, wr_n}), 64'h3, "strobes after reset");
    check("R7", 64'(ready), 64'd0, "ready after reset");
    rst_ni = 1'b1;
    // R3: bank 3 reset timing (32-bit, 1/2/1) before any config
    access(1'b0, 26'h3000040, 32'h0, 1'b0);
    cfg_bank_wr(0, 2, 0, 1, 0);
    cfg_bank_wr(1, 1, 2, 3, 1);
    cfg_bank_wr(2, 0, 1, 0, 2); // active 0 acts as 1 (R4)
    for (int i = 0; i < 10; i++)
      access(VEC[i][58], VEC[i][57:32], VEC[i][31:0], 1'b0);
    // R2: bank 0 hole edges
    access(1'b0, 26'h0E00000, 32'h0, 1'b1);
    access(1'b1, 26'h0FFFFFF, 32'hDEADBEEF, 1'b1);
    // R3: reconfigure bank 1 only; bank 0 and bank 3 keep their settings
    cfg_bank_wr(1, 0, 0, 1, 0);
    access(1'b0, 26'h1234567, 32'h0, 1'b0);
    access(1'b1, 26'h0000001, 32'h55AA33CC, 1'b0);
    access(1'b1, 26'h3000002, 32'h76543210, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule